// File: doc/BRIEF.md
# Dual-Tag Virtually Indexed Data Cache

This block is a read-lookup data cache that is always indexed from the virtual address. Each line can hold either a virtual tag or a physical tag, and a per-line kind flag records which one. The requester chooses the kind on every access. Private data uses the virtual tag taken from the upper address bits, so it needs no translation. Shared data presents a physical tag and physical colour bits. The colour bits are the index bits that lie above the page boundary, and for a shared access they replace the matching virtual index bits. As a result, every alias of a shared buffer lands on one set and one line.

A miss issues one line request on a simple memory port. The request carries the line address built from whichever tag kind the access used, together with that kind. When the line returns, it is written into the chosen way with its tag and kind, and the missed word goes back to the requester. The block is parameterised for a direct-mapped or a 2-way organisation. The 2-way organisation keeps one recency bit per set.

Top module: `dualtag_vicache`

## Requirements
- R1: After synchronous active-high reset, every line is invalid, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The first lookup of any address then misses.
- R2: A virtual-kind access (`req_phys`=0) uses set `req_vaddr[12:5]` and tag `req_vaddr[31:13]`. On a hit, `resp_valid` rises for one cycle two clock edges after acceptance, with `resp_hit`=1 and `resp_data` equal to word `req_vaddr[4:2]` of the line. Word w occupies bits [32w+31:32w] of the line.
- R3: A lookup hits only when the line is valid, its stored kind flag equals the access kind, and its stored tag equals the presented tag. A virtual line and a physical line with equal tag bits in the same set never hit for each other's kind.
- R4: A physical-kind access (`req_phys`=1) compares against `req_ptag`. Two accesses with different virtual addresses but equal `req_ptag`, equal `req_pss` and equal `req_vaddr[11:5]` hit the same line.
- R5: For a physical-kind access, the set index is {`req_pss`, `req_vaddr[11:5]`}: the colour bit replaces `req_vaddr[12]`. The same physical tag with a different colour bit selects a different set.
- R6: A miss drives `mem_req_valid` for exactly one cycle. `mem_req_addr` is {tag, set, 5'b0}, using the tag and set of R2 or R5, and `mem_req_phys` equals the access kind. The edge on which `mem_rsp_valid` is 1 fills the line. The next cycle gives `resp_valid`=1, `resp_hit`=0 and the requested word of `mem_rsp_line`.
- R7: With 2 ways, a fill goes to an invalid way if one exists, else to the least recently used way. Both a hit and a fill make the touched way most recently used.
- R8: `req_ready` is 0 from the cycle after acceptance until the response cycle. Each accepted request produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_phys | input | 1 | Access kind: 0 virtual tag, 1 physical tag |
| req_ptag | input | 19 | Physical tag for a physical-kind access |
| req_pss | input | 1 | Physical colour bit for a physical-kind access |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 when the response came from a hit |
| resp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | One-cycle line request on a miss |
| mem_req_addr | output | 32 | Line-aligned fill address |
| mem_req_phys | output | 1 | Kind of the fill address |
| mem_rsp_valid | input | 1 | Fill line strobe |
| mem_rsp_line | input | 256 | Fill line contents |

## Verification
The checker tests the handshake on every cycle. It confirms that acceptance drops `req_ready`, that a memory request is a single pulse issued only while busy, and that every response is a single pulse. It also confirms that a miss response follows a fill strobe and that the cache is idle when it responds. Only the bench's scenarios can show which lookups hit. Those scenarios cover kind-flag separation, aliases of a shared buffer meeting on one line, colour-bit substitution moving the set, the exact fill address, and victim choice by recency in a set contended by three tags.

// File: rtl/dualtag_pkg.sv
package dualtag_pkg;

    localparam int unsigned DEF_ADDR_W   = 32;
    localparam int unsigned DEF_PAGE_W   = 12;
    localparam int unsigned DEF_OFF_W    = 5;
    localparam int unsigned DEF_SPAN_W   = 13;
    localparam int unsigned DEF_WAYS     = 2;
    localparam int unsigned DEF_WORD_W   = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } cstate_t;

    typedef enum logic {
        TAG_VIRT = 1'b0,
        TAG_PHYS = 1'b1
    } tag_kind_t;

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v > 0) ? v : 1;
    endfunction

endpackage

// File: rtl/dualtag_addr_map.sv
module dualtag_addr_map
    import dualtag_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned SPAN_W = DEF_SPAN_W,
    localparam int unsigned SET_W = SPAN_W - OFF_W,
    localparam int unsigned TAG_W = ADDR_W - SPAN_W,
    localparam int unsigned SS_W  = SPAN_W - PAGE_W,
    localparam int unsigned SSP_W = at_least_one(SS_W),
    localparam int unsigned WSEL_W = OFF_W - 2
) (
    input  logic [ADDR_W-1:0]       vaddr,
    input  tag_kind_t               kind,
    input  logic [TAG_W-1:0]        ptag,
    input  logic [SSP_W-1:0]        pss,
    output logic [SET_W-1:0]        set_idx,
    output logic [TAG_W-1:0]        tag,
    output logic [WSEL_W-1:0]       word_sel,
    output logic [ADDR_W-OFF_W-1:0] line_addr
);

    logic [1:0] unused_lo;
    assign unused_lo = vaddr[1:0];

    generate
        if (SS_W > 0) begin : g_colour
            // Shared accesses swap the colour bits for the translated ones.
            assign set_idx = (kind == TAG_PHYS) ? {pss, vaddr[PAGE_W-1:OFF_W]}
                                                : vaddr[SPAN_W-1:OFF_W];
        end else begin : g_nocolour
            logic [SSP_W-1:0] unused_pss;
            assign unused_pss = pss;
            assign set_idx = vaddr[SPAN_W-1:OFF_W];
        end
    endgenerate

    assign tag       = (kind == TAG_PHYS) ? ptag : vaddr[ADDR_W-1:SPAN_W];
    assign word_sel  = vaddr[OFF_W-1:2];
    assign line_addr = {tag, set_idx};

endmodule

// File: rtl/dualtag_way.sv
module dualtag_way
    import dualtag_pkg::*;
#(
    parameter int unsigned SET_W  = 8,
    parameter int unsigned TAG_W  = 19,
    parameter int unsigned LINE_W = 256,
    localparam int unsigned SETS  = 1 << SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  tag_kind_t         cmp_kind,
    output logic              hit,
    output logic              line_valid,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  tag_kind_t         wr_kind,
    input  logic [LINE_W-1:0] wr_line
);

    logic [SETS-1:0]   vld_q;
    tag_kind_t         kind_q [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] dat_q  [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            kind_q[wr_set] <= wr_kind;
            tag_q[wr_set]  <= wr_tag;
            dat_q[wr_set]  <= wr_line;
        end
    end

    assign line_valid = vld_q[rd_set];
    assign hit        = vld_q[rd_set] && (kind_q[rd_set] == cmp_kind)
                        && (tag_q[rd_set] == cmp_tag);
    assign rd_line    = dat_q[rd_set];

endmodule

// File: rtl/dualtag_victim.sv
module dualtag_victim
    import dualtag_pkg::*;
#(
    parameter int unsigned WAYS  = DEF_WAYS,
    parameter int unsigned SET_W = 8,
    localparam int unsigned WIDX_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int unsigned SETS   = 1 << SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [WAYS-1:0]   way_valid,
    input  logic              touch_en,
    input  logic [WIDX_W-1:0] touch_way,
    output logic [WIDX_W-1:0] victim
);

    generate
        if (WAYS == 2) begin : g_two
            logic [SETS-1:0] mru_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    mru_q <= '0;
                end else if (touch_en) begin
                    mru_q[set_idx] <= touch_way[0];
                end
            end

            always_comb begin
                if (!way_valid[0])      victim = 1'b0;
                else if (!way_valid[1]) victim = 1'b1;
                else                    victim = ~mru_q[set_idx];
            end
        end else begin : g_one
            logic unused_in;
            assign unused_in = ^{clk, rst, set_idx, way_valid, touch_en, touch_way};
            assign victim = '0;
        end
    endgenerate

endmodule

// File: rtl/dualtag_vicache.sv
module dualtag_vicache
    import dualtag_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned SPAN_W = DEF_SPAN_W,
    parameter int unsigned WAYS   = DEF_WAYS,
    parameter int unsigned WORD_W = DEF_WORD_W,
    localparam int unsigned SET_W   = SPAN_W - OFF_W,
    localparam int unsigned TAG_W   = ADDR_W - SPAN_W,
    localparam int unsigned SSP_W   = at_least_one(SPAN_W - PAGE_W),
    localparam int unsigned LINE_W  = 8 << OFF_W,
    localparam int unsigned WSEL_W  = OFF_W - 2,
    localparam int unsigned LADDR_W = ADDR_W - OFF_W,
    localparam int unsigned WIDX_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_phys,
    input  logic [TAG_W-1:0]  req_ptag,
    input  logic [SSP_W-1:0]  req_pss,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_phys,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_line
);

    cstate_t state_q;

    tag_kind_t          in_kind;
    logic [SET_W-1:0]   in_set;
    logic [TAG_W-1:0]   in_tag;
    logic [WSEL_W-1:0]  in_word;
    logic [LADDR_W-1:0] in_laddr;

    tag_kind_t          r_kind;
    logic [SET_W-1:0]   r_set;
    logic [TAG_W-1:0]   r_tag;
    logic [WSEL_W-1:0]  r_word;
    logic [LADDR_W-1:0] r_laddr;

    logic [WAYS-1:0]    hitv;
    logic [WAYS-1:0]    vldv;
    logic [LINE_W-1:0]  way_line [WAYS];
    logic [WAYS-1:0]    wr_en;
    logic [LINE_W-1:0]  hit_line;
    logic [WIDX_W-1:0]  hit_way;
    logic [WIDX_W-1:0]  victim;
    logic               hit_any;
    logic               accept;
    logic               look_hit;
    logic               fill_fire;

    assign in_kind = req_phys ? TAG_PHYS : TAG_VIRT;

    dualtag_addr_map #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SPAN_W(SPAN_W)
    ) u_map (
        .vaddr    (req_vaddr),
        .kind     (in_kind),
        .ptag     (req_ptag),
        .pss      (req_pss),
        .set_idx  (in_set),
        .tag      (in_tag),
        .word_sel (in_word),
        .line_addr(in_laddr)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit_any   = |hitv;
    assign look_hit  = (state_q == ST_LOOK) && hit_any;
    assign fill_fire = (state_q == ST_FILL) && mem_rsp_valid;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign wr_en[w] = fill_fire && (victim == WIDX_W'(w));

            dualtag_way #(
                .SET_W(SET_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
            ) u_way (
                .clk       (clk),
                .rst       (rst),
                .rd_set    (r_set),
                .cmp_tag   (r_tag),
                .cmp_kind  (r_kind),
                .hit       (hitv[w]),
                .line_valid(vldv[w]),
                .rd_line   (way_line[w]),
                .wr_en     (wr_en[w]),
                .wr_set    (r_set),
                .wr_tag    (r_tag),
                .wr_kind   (r_kind),
                .wr_line   (mem_rsp_line)
            );
        end

        if (WAYS == 2) begin : g_hit2
            assign hit_way = hitv[WAYS-1];
        end else begin : g_hit1
            assign hit_way = '0;
        end
    endgenerate

    always_comb begin
        hit_line = way_line[0];
        for (int w = 0; w < WAYS; w++) begin
            if (hitv[w]) hit_line = way_line[w];
        end
    end

    dualtag_victim #(
        .WAYS(WAYS), .SET_W(SET_W)
    ) u_victim (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (r_set),
        .way_valid(vldv),
        .touch_en (look_hit || fill_fire),
        .touch_way(fill_fire ? victim : hit_way),
        .victim   (victim)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            r_kind  <= in_kind;
            r_set   <= in_set;
            r_tag   <= in_tag;
            r_word  <= in_word;
            r_laddr <= in_laddr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_data     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_phys  <= 1'b0;
        end else begin
            resp_valid    <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) state_q <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (hit_any) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= hit_line[int'(r_word)*WORD_W +: WORD_W];
                        state_q    <= ST_IDLE;
                    end else begin
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= {r_laddr, {OFF_W{1'b0}}};
                        mem_req_phys  <= (r_kind == TAG_PHYS);
                        state_q       <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_data  <= mem_rsp_line[int'(r_word)*WORD_W +: WORD_W];
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dualtag_vicache_chk.sv
module dualtag_vicache_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic resp_hit,
    input logic mem_req_valid,
    input logic mem_rsp_valid
);

    // R8: acceptance makes the cache busy on the next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: a response lasts one cycle
    a_r8_resp_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R6: a line request lasts one cycle
    a_r6_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R6: a line request only appears while a lookup is in flight
    a_r6_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R6: a miss response follows the fill strobe
    a_r6_miss_after_fill: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> $past(mem_rsp_valid));

    // R2: the cache is idle again when it responds
    a_r2_resp_idle: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);

endmodule

bind dualtag_vicache dualtag_vicache_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .mem_req_valid(mem_req_valid),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/dualtag_vicache_tb_top.sv
module dualtag_vicache_tb_top;

    localparam int LINE_W = 256;
    localparam int WPL    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_phys = 1'b0;
    logic [18:0] req_ptag = '0;
    logic [0:0]  req_pss = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [31:0] resp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_phys;
    logic        mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_line = '0;

    int checks = 0;
    int failures = 0;

    bit          exp_hit_q [$];
    logic [31:0] exp_data_q [$];
    string       exp_tag_q [$];
    logic [31:0] exp_maddr_q [$];
    bit          exp_mphys_q [$];

    always #2.5 clk = ~clk;

    dualtag_vicache dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_phys(req_phys), .req_ptag(req_ptag), .req_pss(req_pss),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_phys(mem_req_phys), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_line(mem_rsp_line)
    );

    function automatic logic [31:0] memw(input bit ph, input logic [31:0] la, input int w);
        return (la * 32'h9E37_79B1) ^ (32'(w) * 32'h0101_0101) ^ (ph ? 32'h5A5A_0000 : 32'h0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Driver: computes the expected result from the requirements and queues it.
    task automatic access(input logic [31:0] va, input bit ph, input logic [18:0] pt,
                          input bit ps, input bit exp_hit, input string tag);
        logic [31:0] eff;
        eff = ph ? {pt, ps, va[11:5], 5'b0} : {va[31:5], 5'b0};
        exp_hit_q.push_back(exp_hit);
        exp_data_q.push_back(memw(ph, eff, int'(va[4:2])));
        exp_tag_q.push_back(tag);
        if (!exp_hit) begin
            exp_maddr_q.push_back(eff);
            exp_mphys_q.push_back(ph);
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_phys  = ph;
        req_ptag  = pt;
        req_pss   = ps;
        @(negedge clk);
        req_valid = 1'b0;
        check({"R8 busy after accept ", tag}, 32'(req_ready), 32'd0);
        while (exp_hit_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each response.
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                if (exp_hit_q.size() == 0) begin
                    check("R8 unexpected response", 32'd1, 32'd0);
                end else begin
                    string t;
                    t = exp_tag_q.pop_front();
                    check({t, " hit"}, 32'(resp_hit), 32'(exp_hit_q[0]));
                    check({t, " data"}, resp_data, exp_data_q.pop_front());
                    void'(exp_hit_q.pop_front());
                end
            end
        end
    end

    // Memory model: checks the fill address (R6) and returns a line.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [31:0] a;
                bit p;
                a = mem_req_addr;
                p = mem_req_phys;
                if (exp_maddr_q.size() == 0) begin
                    check("R6 unexpected line request", 32'd1, 32'd0);
                end else begin
                    check("R6 fill address", a, exp_maddr_q.pop_front());
                    check("R6 fill kind", 32'(p), 32'(exp_mphys_q.pop_front()));
                end
                repeat (2) @(negedge clk);
                for (int w = 0; w < WPL; w++) mem_rsp_line[w*32 +: 32] = memw(p, a, w);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ready", 32'(req_ready), 32'd1);
        check("R1 reset resp_valid", 32'(resp_valid), 32'd0);
        check("R1 reset mem_req_valid", 32'(mem_req_valid), 32'd0);

        // R1/R2: private data, first miss then virtual-tag hits
        access(32'h0001_0040, 1'b0, 19'h0, 1'b0, 1'b0, "R1 first access misses");
        access(32'h0001_0044, 1'b0, 19'h0, 1'b0, 1'b1, "R2 virtual hit word1");
        access(32'h0001_005C, 1'b0, 19'h0, 1'b0, 1'b1, "R2 virtual hit word7");

        // R3: equal tag bits but physical kind must miss; both kinds then coexist
        access(32'h0001_0040, 1'b1, 19'h8, 1'b0, 1'b0, "R3 kind mismatch misses");
        access(32'h0001_0048, 1'b1, 19'h8, 1'b0, 1'b1, "R3 physical line hits");
        access(32'h0001_0040, 1'b0, 19'h0, 1'b0, 1'b1, "R3 virtual line kept");

        // R4/R5: aliases of one shared buffer meet on one line
        access(32'h0000_2100, 1'b1, 19'h55, 1'b1, 1'b0, "R5 shared fill");
        access(32'h0004_7104, 1'b1, 19'h55, 1'b1, 1'b1, "R4 alias hits");
        access(32'h0123_6108, 1'b1, 19'h55, 1'b1, 1'b1, "R4 second alias hits");
        access(32'h0004_7100, 1'b1, 19'h55, 1'b0, 1'b0, "R5 other colour misses");

        // R7: recency-based victim in set 3
        access(32'h0010_0060, 1'b0, 19'h0, 1'b0, 1'b0, "R7 T1 fill");
        access(32'h0020_0060, 1'b0, 19'h0, 1'b0, 1'b0, "R7 T2 fill");
        access(32'h0010_0064, 1'b0, 19'h0, 1'b0, 1'b1, "R7 T1 hit");
        access(32'h0030_0060, 1'b0, 19'h0, 1'b0, 1'b0, "R7 T3 evicts T2");
        access(32'h0010_0068, 1'b0, 19'h0, 1'b0, 1'b1, "R7 T1 survives");
        access(32'h0020_0060, 1'b0, 19'h0, 1'b0, 1'b0, "R7 T2 was evicted");
        access(32'h0030_0060, 1'b0, 19'h0, 1'b0, 1'b0, "R7 T3 was evicted");
        access(32'h0020_007C, 1'b0, 19'h0, 1'b0, 1'b1, "R7 T2 refilled");

        repeat (4) @(negedge clk);
        check("R8 all responses seen", 32'(exp_data_q.size()), 32'd0);
        check("R6 all fills seen", 32'(exp_maddr_q.size()), 32'd0);
        finish_up();
    end

endmodule